// File: doc/BRIEF.md
# Dataflow Grid ALU Node

This block is a single processing node of a two-dimensional array of ALUs. Instructions are placed in it ahead of time, one per frame slot, through a load interface. Operands reach it as packets on three input ports from neighbouring nodes. Each packet names a frame slot and an operand position. A slot becomes eligible once every operand its opcode needs has arrived. The node then issues it to a local integer ALU, one instruction per cycle. No shared issue window exists and no registers are renamed.

The result goes point-to-point to at most three consumer targets stored with the instruction. Each target is sent out of one of three output ports, chosen by the direction of the consumer's grid offset. An output port that holds a value not yet taken stalls later results. A conditional move forwards its data only when its predicate is non-zero. A plain forwarding opcode re-sends a value, so a value can reach more than three consumers. A per-frame clear input drops the collected operand state of a frame when its block commits or is flushed.

Top module: `grid_alu_node`

## Requirements
- R1: The node has three operand input ports and three result output ports. Each frame index selects exactly one instruction slot (8 slots by default). An arriving operand is stored only in the slot named by its frame field.
- R2: A target/packet word is 11 bits: [10:8] signed row offset, [7:5] signed column offset, [4:2] frame index, [1:0] operand position (0 = left, 1 = right, 2 = predicate). Position 3 is dropped and sets nothing.
- R3: A slot issues only when all operands its opcode needs are present. Binary opcodes need left and right. Move (0x08) and forward (0x09) need left. Conditional move (0x0A) needs left and predicate. Opcode 0x00 and unknown opcodes never issue.
- R4: At most one slot issues per cycle. Among complete slots, the lowest-numbered slot goes first. Issuing clears that slot's operand-ready state.
- R5: The ALU computes: 0x01 add, 0x02 subtract (left minus right), 0x03 and, 0x04 or, 0x05 xor, 0x06 shift left by right[4:0], 0x07 logical shift right by right[4:0], 0x0B signed less-than giving 1 or 0. Opcodes 0x08 and 0x09 forward the left operand.
- R6: Conditional move (0x0A) forwards the left operand when the predicate operand is non-zero. When the predicate is zero it sends nothing.
- R7: The result goes to every target enabled in the 3-bit target mask, carrying that target word unchanged. Column offset non-zero selects port 0. Otherwise a positive row offset selects port 1, and all other cases select port 2. With ports free, the result is valid two edges after the edge that captured the last needed operand.
- R8: Enabled targets that map to the same output port leave on consecutive cycles, in ascending target index.
- R9: An output port holding a value with its ready input low keeps that value and valid stable. Later results for that port wait.
- R10: A clear bit for a frame, or a new load into it, discards the operands that frame has gathered.
- R11: During and after reset all output valids are low and no slot holds operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load an instruction into a frame slot |
| ld_frame | input | 3 | Frame slot to load |
| ld_opcode | input | 8 | Opcode of the loaded instruction |
| ld_tmask | input | 3 | Enable per consumer target |
| ld_tgts | input | 33 | Three 11-bit consumer target words, target 0 in the low bits |
| in_valid | input | 3 | Operand packet present, one bit per input port |
| in_tgt | input | 33 | Packet word per input port (frame and position used) |
| in_data | input | 96 | 32-bit operand value per input port |
| clr_frames | input | 8 | Per-frame clear of gathered operands |
| out_ready | input | 3 | Neighbour accepts the value on each output port |
| out_valid | output | 3 | Result present on each output port |
| out_tgt | output | 33 | Target word carried on each output port |
| out_data | output | 96 | Result value on each output port |

## Verification
The bench walks every ALU opcode, including a shift amount above 31 that must wrap. A design that used the full right operand there would send zero. A slot that gets only one of two operands must stay silent. So must a slot whose gathered operand was wiped by a clear or a reload. A design that tracked readiness loosely would fire early or use a stale value. Two slots completing together must leave in slot order. Two targets on one port must serialise in order. A port held busy must keep its value stable while a second result waits behind it. A design that dropped or overwrote either value would show a missing or wrong word. A false conditional move and a position-3 packet must produce nothing at all.

// File: rtl/gan_pkg.sv
package gan_pkg;
  localparam int NPORT = 3;
  localparam int NTGT  = 3;
  localparam int OFFW  = 3;
  localparam int NOPND = 3;

  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_ADD  = 8'h01;
  localparam logic [7:0] OP_SUB  = 8'h02;
  localparam logic [7:0] OP_AND  = 8'h03;
  localparam logic [7:0] OP_OR   = 8'h04;
  localparam logic [7:0] OP_XOR  = 8'h05;
  localparam logic [7:0] OP_SHL  = 8'h06;
  localparam logic [7:0] OP_SHR  = 8'h07;
  localparam logic [7:0] OP_MOV  = 8'h08;
  localparam logic [7:0] OP_FWD  = 8'h09;
  localparam logic [7:0] OP_CMOV = 8'h0A;
  localparam logic [7:0] OP_SLT  = 8'h0B;

  // operand positions: bit 0 left, bit 1 right, bit 2 predicate
  function automatic logic [NOPND-1:0] need_of(input logic [7:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
      OP_SHL, OP_SHR, OP_SLT: need_of = 3'b011;
      OP_MOV, OP_FWD:         need_of = 3'b001;
      OP_CMOV:                need_of = 3'b101;
      default:                need_of = 3'b000;
    endcase
  endfunction

  // next-hop port from the consumer's offset direction
  function automatic logic [1:0] port_of(input logic [OFFW-1:0] row,
                                         input logic [OFFW-1:0] col);
    if (col != '0)                      port_of = 2'd0;
    else if (!row[OFFW-1] && row != '0) port_of = 2'd1;
    else                                port_of = 2'd2;
  endfunction
endpackage

// File: rtl/gan_slot_store.sv
module gan_slot_store
  import gan_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int DW    = 32,
  parameter int FW    = 3,
  parameter int TGTW  = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [FW-1:0]          ld_frame,
  input  logic [7:0]             ld_opcode,
  input  logic [NTGT-1:0]        ld_tmask,
  input  logic [NTGT*TGTW-1:0]   ld_tgts,
  input  logic [NPORT-1:0]       in_valid,
  input  logic [NPORT*TGTW-1:0]  in_tgt,
  input  logic [NPORT*DW-1:0]    in_data,
  input  logic [NSLOT-1:0]       clr_frames,
  input  logic                   iss_go,
  input  logic [FW-1:0]          iss_slot,
  output logic [NSLOT-1:0]       complete,
  output logic [7:0]             rd_op,
  output logic [DW-1:0]          rd_a,
  output logic [DW-1:0]          rd_b,
  output logic [DW-1:0]          rd_p,
  output logic [NTGT-1:0]        rd_tmask,
  output logic [NTGT*TGTW-1:0]   rd_tgts
);
  logic [7:0]           op_q    [NSLOT];
  logic [NOPND-1:0]     rdy_q   [NSLOT];
  logic [NOPND-1:0]     rdy_d   [NSLOT];
  logic [DW-1:0]        val_q   [NSLOT][NOPND];
  logic [NTGT-1:0]      tmask_q [NSLOT];
  logic [NTGT*TGTW-1:0] tgts_q  [NSLOT];

  logic [FW-1:0] arr_frame [NPORT];
  logic [1:0]    arr_pos   [NPORT];
  logic [DW-1:0] arr_data  [NPORT];
  logic          arr_ok    [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_arrive
    assign arr_frame[p] = in_tgt[p*TGTW+2 +: FW];
    assign arr_pos[p]   = in_tgt[p*TGTW +: 2];
    assign arr_data[p]  = in_data[p*DW +: DW];
    assign arr_ok[p]    = in_valid[p] && (in_tgt[p*TGTW +: 2] != 2'd3);
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      rdy_d[i] = rdy_q[i];
      if (iss_go && iss_slot == FW'(i)) rdy_d[i] = '0;
      for (int p = 0; p < NPORT; p++)
        if (arr_ok[p] && arr_frame[p] == FW'(i)) rdy_d[i][arr_pos[p]] = 1'b1;
      if (clr_frames[i]) rdy_d[i] = '0;
      if (ld_valid && ld_frame == FW'(i)) rdy_d[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        rdy_q[i]   <= '0;
        op_q[i]    <= OP_NOP;
        tmask_q[i] <= '0;
        tgts_q[i]  <= '0;
        for (int k = 0; k < NOPND; k++) val_q[i][k] <= '0;
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        rdy_q[i] <= rdy_d[i];
        if (ld_valid && ld_frame == FW'(i)) begin
          op_q[i]    <= ld_opcode;
          tmask_q[i] <= ld_tmask;
          tgts_q[i]  <= ld_tgts;
        end
        for (int p = 0; p < NPORT; p++)
          if (arr_ok[p] && arr_frame[p] == FW'(i)) val_q[i][arr_pos[p]] <= arr_data[p];
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_wake
    logic [NOPND-1:0] need;
    assign need        = need_of(op_q[i]);
    assign complete[i] = (need != '0) && ((rdy_q[i] & need) == need);
  end

  assign rd_op    = op_q[iss_slot];
  assign rd_a     = val_q[iss_slot][0];
  assign rd_b     = val_q[iss_slot][1];
  assign rd_p     = val_q[iss_slot][2];
  assign rd_tmask = tmask_q[iss_slot];
  assign rd_tgts  = tgts_q[iss_slot];
endmodule

// File: rtl/gan_pick.sv
module gan_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/gan_emit.sv
module gan_emit
  import gan_pkg::*;
#(
  parameter int DW   = 32,
  parameter int TGTW = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iss_go,
  input  logic [7:0]             iss_op,
  input  logic [DW-1:0]          iss_a,
  input  logic [DW-1:0]          iss_b,
  input  logic [DW-1:0]          iss_p,
  input  logic [NTGT-1:0]        iss_tmask,
  input  logic [NTGT*TGTW-1:0]   iss_tgts,
  input  logic [NPORT-1:0]       out_ready,
  output logic                   can_take,
  output logic [NTGT-1:0]        pend,
  output logic [NPORT-1:0]       out_valid,
  output logic [NPORT*TGTW-1:0]  out_tgt,
  output logic [NPORT*DW-1:0]    out_data
);
  localparam int SHW = $clog2(DW);

  function automatic logic [DW-1:0] alu_eval(input logic [7:0] op,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    case (op)
      OP_ADD:  alu_eval = a + b;
      OP_SUB:  alu_eval = a - b;
      OP_AND:  alu_eval = a & b;
      OP_OR:   alu_eval = a | b;
      OP_XOR:  alu_eval = a ^ b;
      OP_SHL:  alu_eval = a << b[SHW-1:0];
      OP_SHR:  alu_eval = a >> b[SHW-1:0];
      OP_SLT:  alu_eval = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: alu_eval = a;
    endcase
  endfunction

  function automatic logic fwd_ok(input logic [7:0] op, input logic [DW-1:0] p);
    fwd_ok = (op != OP_CMOV) || (p != '0);
  endfunction

  logic [NTGT-1:0]      pend_q;
  logic [DW-1:0]        res_q;
  logic [NTGT*TGTW-1:0] tgts_q;
  logic [1:0]           tport  [NTGT];
  logic [NPORT-1:0]     pfree;
  logic [NPORT-1:0]     send;
  logic [1:0]           send_t [NPORT];
  logic [NTGT-1:0]      taken;

  for (genvar t = 0; t < NTGT; t++) begin : g_route
    assign tport[t] = port_of(tgts_q[t*TGTW+TGTW-1 -: OFFW],
                              tgts_q[t*TGTW+TGTW-1-OFFW -: OFFW]);
  end

  always_comb begin
    taken = '0;
    for (int p = 0; p < NPORT; p++) begin
      send[p]   = 1'b0;
      send_t[p] = '0;
      if (pfree[p]) begin
        for (int t = NTGT - 1; t >= 0; t--) begin
          if (pend_q[t] && tport[t] == 2'(p)) begin
            send[p]   = 1'b1;
            send_t[p] = 2'(t);
          end
        end
      end
      if (send[p]) taken[send_t[p]] = 1'b1;
    end
  end

  assign can_take = (pend_q & ~taken) == '0;
  assign pend     = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      res_q  <= '0;
      tgts_q <= '0;
    end else if (iss_go) begin
      pend_q <= fwd_ok(iss_op, iss_p) ? iss_tmask : '0;
      res_q  <= alu_eval(iss_op, iss_a, iss_b);
      tgts_q <= iss_tgts;
    end else begin
      pend_q <= pend_q & ~taken;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic            v_q;
    logic [TGTW-1:0] t_q;
    logic [DW-1:0]   d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else if (send[p]) begin
        v_q <= 1'b1;
        t_q <= tgts_q[send_t[p]*TGTW +: TGTW];
        d_q <= res_q;
      end else if (out_ready[p]) begin
        v_q <= 1'b0;
      end
    end
    assign pfree[p]                  = !v_q || out_ready[p];
    assign out_valid[p]              = v_q;
    assign out_tgt[p*TGTW +: TGTW]   = t_q;
    assign out_data[p*DW +: DW]      = d_q;
  end
endmodule

// File: rtl/grid_alu_node.sv
module grid_alu_node
  import gan_pkg::*;
#(
  parameter  int NSLOT = 8,
  parameter  int DW    = 32,
  localparam int FW    = $clog2(NSLOT),
  localparam int TGTW  = 2*OFFW + FW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_valid,
  input  logic [FW-1:0]         ld_frame,
  input  logic [7:0]            ld_opcode,
  input  logic [NTGT-1:0]       ld_tmask,
  input  logic [NTGT*TGTW-1:0]  ld_tgts,
  input  logic [NPORT-1:0]      in_valid,
  input  logic [NPORT*TGTW-1:0] in_tgt,
  input  logic [NPORT*DW-1:0]   in_data,
  input  logic [NSLOT-1:0]      clr_frames,
  input  logic [NPORT-1:0]      out_ready,
  output logic [NPORT-1:0]      out_valid,
  output logic [NPORT*TGTW-1:0] out_tgt,
  output logic [NPORT*DW-1:0]   out_data
);
  logic [NSLOT-1:0]     complete;
  logic                 pick_v;
  logic [FW-1:0]        iss_slot;
  logic                 can_take;
  logic                 iss_go;
  logic [7:0]           iss_op;
  logic [DW-1:0]        iss_a, iss_b, iss_p;
  logic [NTGT-1:0]      iss_tmask;
  logic [NTGT*TGTW-1:0] iss_tgts;
  logic [NTGT-1:0]      emit_pend;

  assign iss_go = pick_v && can_take;

  gan_slot_store #(.NSLOT(NSLOT), .DW(DW), .FW(FW), .TGTW(TGTW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_frame(ld_frame), .ld_opcode(ld_opcode),
    .ld_tmask(ld_tmask), .ld_tgts(ld_tgts),
    .in_valid(in_valid), .in_tgt(in_tgt), .in_data(in_data),
    .clr_frames(clr_frames), .iss_go(iss_go), .iss_slot(iss_slot),
    .complete(complete), .rd_op(iss_op), .rd_a(iss_a), .rd_b(iss_b),
    .rd_p(iss_p), .rd_tmask(iss_tmask), .rd_tgts(iss_tgts)
  );

  gan_pick #(.N(NSLOT), .IW(FW)) u_pick (
    .req(complete), .gnt_valid(pick_v), .gnt_idx(iss_slot)
  );

  gan_emit #(.DW(DW), .TGTW(TGTW)) u_emit (
    .clk(clk), .rst_n(rst_n), .iss_go(iss_go), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .iss_p(iss_p),
    .iss_tmask(iss_tmask), .iss_tgts(iss_tgts), .out_ready(out_ready),
    .can_take(can_take), .pend(emit_pend),
    .out_valid(out_valid), .out_tgt(out_tgt), .out_data(out_data)
  );
endmodule

// File: rtl/grid_alu_node_chk.sv
module grid_alu_node_chk
  import gan_pkg::*;
#(
  parameter  int NSLOT = 8,
  parameter  int DW    = 32,
  localparam int FW    = $clog2(NSLOT),
  localparam int TGTW  = 2*OFFW + FW + 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NSLOT-1:0]      complete,
  input logic                  iss_go,
  input logic [FW-1:0]         iss_slot,
  input logic [7:0]            iss_op,
  input logic [DW-1:0]         iss_p,
  input logic [NTGT-1:0]       emit_pend,
  input logic [NPORT-1:0]      out_valid,
  input logic [NPORT-1:0]      out_ready,
  input logic [NPORT*TGTW-1:0] out_tgt,
  input logic [NPORT*DW-1:0]   out_data
);
  logic [NSLOT-1:0] below;
  assign below = (NSLOT'(1) << iss_slot) - NSLOT'(1);

  p_fire_when_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_go |-> complete[iss_slot]);

  p_lowest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_go |-> ((complete & below) == '0));

  p_cmove_false_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_go && iss_op == OP_CMOV && iss_p == '0) |=> (emit_pend == '0));

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    p_port_direction_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] |-> (port_of(out_tgt[p*TGTW+TGTW-1 -: OFFW],
                                out_tgt[p*TGTW+TGTW-1-OFFW -: OFFW]) == 2'(p)));

    p_hold_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[p] && !out_ready[p]) |=>
        (out_valid[p] && $stable(out_data[p*DW +: DW]) && $stable(out_tgt[p*TGTW +: TGTW])));
  end
endmodule

bind grid_alu_node grid_alu_node_chk #(.NSLOT(NSLOT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .complete(complete), .iss_go(iss_go),
  .iss_slot(iss_slot), .iss_op(iss_op), .iss_p(iss_p), .emit_pend(emit_pend),
  .out_valid(out_valid), .out_ready(out_ready), .out_tgt(out_tgt), .out_data(out_data)
);

// File: tb/grid_alu_node_bench.sv
module grid_alu_node_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 11;
  localparam int NV = 15;

  typedef struct packed {
    logic [7:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] p;
    logic        v;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'h01, 32'd5,          32'd7,          32'd0, 1'b1, 32'd12},
    '{8'h02, 32'd3,          32'd5,          32'd0, 1'b1, 32'hFFFF_FFFE},
    '{8'h03, 32'hF0F0_00FF,  32'h0FF0_0F0F,  32'd0, 1'b1, 32'h00F0_000F},
    '{8'h04, 32'hF000_0000,  32'd1,          32'd0, 1'b1, 32'hF000_0001},
    '{8'h05, 32'hAAAA_AAAA,  32'hFFFF_0000,  32'd0, 1'b1, 32'h5555_AAAA},
    '{8'h06, 32'd1,          32'd31,         32'd0, 1'b1, 32'h8000_0000},
    '{8'h06, 32'd1,          32'd33,         32'd0, 1'b1, 32'd2},
    '{8'h07, 32'h8000_0000,  32'd4,          32'd0, 1'b1, 32'h0800_0000},
    '{8'h0B, 32'hFFFF_FFFF,  32'd1,          32'd0, 1'b1, 32'd1},
    '{8'h0B, 32'd5,          32'd3,          32'd0, 1'b1, 32'd0},
    '{8'h08, 32'h0000_1234,  32'h0000_9999,  32'd0, 1'b1, 32'h0000_1234},
    '{8'h09, 32'hCAFE_0000,  32'd0,          32'd0, 1'b1, 32'hCAFE_0000},
    '{8'h0A, 32'd77,         32'd0,          32'd1, 1'b1, 32'd77},
    '{8'h0A, 32'd77,         32'd0,          32'd0, 1'b0, 32'd0},
    '{8'h00, 32'd1,          32'd2,          32'd3, 1'b0, 32'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic [2:0]    ld_frame = '0;
  logic [7:0]    ld_opcode = '0;
  logic [2:0]    ld_tmask = '0;
  logic [3*TW-1:0] ld_tgts = '0;
  logic [2:0]    in_valid = '0;
  logic [3*TW-1:0] in_tgt = '0;
  logic [95:0]   in_data = '0;
  logic [7:0]    clr_frames = '0;
  logic [2:0]    out_ready = 3'b111;
  logic [2:0]    out_valid;
  logic [3*TW-1:0] out_tgt;
  logic [95:0]   out_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grid_alu_node u_grid_alu_node (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_frame(ld_frame),
    .ld_opcode(ld_opcode), .ld_tmask(ld_tmask), .ld_tgts(ld_tgts),
    .in_valid(in_valid), .in_tgt(in_tgt), .in_data(in_data),
    .clr_frames(clr_frames), .out_ready(out_ready), .out_valid(out_valid),
    .out_tgt(out_tgt), .out_data(out_data)
  );

  function automatic logic [TW-1:0] mk_tgt(input logic [2:0] r, input logic [2:0] c,
                                           input logic [2:0] f, input logic [1:0] pos);
    return {r, c, f, pos};
  endfunction

  function automatic logic [TW-1:0] opnd(input logic [2:0] f, input logic [1:0] pos);
    return mk_tgt(3'd0, 3'd0, f, pos);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [2:0] f, input logic [7:0] op, input logic [2:0] m,
                      input logic [TW-1:0] t0, input logic [TW-1:0] t1, input logic [TW-1:0] t2);
    ld_valid = 1'b1; ld_frame = f; ld_opcode = op; ld_tmask = m; ld_tgts = {t2, t1, t0};
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic send(input logic [2:0] vm,
                      input logic [TW-1:0] t0, input logic [TW-1:0] t1, input logic [TW-1:0] t2,
                      input logic [31:0] d0, input logic [31:0] d1, input logic [31:0] d2);
    in_valid = vm; in_tgt = {t2, t1, t0}; in_data = {d2, d1, d0};
    @(negedge clk);
    in_valid = '0;
  endtask

  initial begin
    idle(3);
    chk("R11 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    idle(2);
    chk("R11 out_valid after reset", 32'(out_valid), 32'd0);

    // table walk: slot 0, one target on port 0
    for (int i = 0; i < NV; i++) begin
      load(3'd0, VECS[i].op, 3'b001, mk_tgt(3'd0, 3'd1, 3'd5, 2'd0), '0, '0);
      send(3'b111, opnd(3'd0, 2'd0), opnd(3'd0, 2'd1), opnd(3'd0, 2'd2),
           VECS[i].a, VECS[i].b, VECS[i].p);
      idle(2);
      if (VECS[i].op == 8'h0A) begin
        chk("R6 cmove valid", 32'(out_valid[0]), 32'(VECS[i].v));
        if (VECS[i].v) chk("R6 cmove data", out_data[31:0], VECS[i].exp);
      end else if (VECS[i].op == 8'h00) begin
        chk("R3 nop never issues", 32'(out_valid), 32'd0);
      end else begin
        chk("R5 alu valid", 32'(out_valid[0]), 32'd1);
        chk("R5 alu data", out_data[31:0], VECS[i].exp);
        chk("R7 target word", 32'(out_tgt[TW-1:0]), 32'(mk_tgt(3'd0, 3'd1, 3'd5, 2'd0)));
      end
      idle(2);
    end

    // R3: half the operands is not enough
    load(3'd1, 8'h01, 3'b001, mk_tgt(3'd0, 3'd1, 3'd1, 2'd0), '0, '0);
    send(3'b001, opnd(3'd1, 2'd0), '0, '0, 32'd10, 0, 0);
    idle(3);
    chk("R3 partial operands silent", 32'(out_valid), 32'd0);
    send(3'b010, '0, opnd(3'd1, 2'd1), '0, 0, 32'd20, 0);
    idle(2);
    chk("R3 fires when complete", out_data[31:0], 32'd30);
    idle(2);

    // R1 / R4: two slots complete together, lowest first
    load(3'd2, 8'h08, 3'b001, mk_tgt(3'd0, 3'd2, 3'd0, 2'd0), '0, '0);
    load(3'd5, 8'h08, 3'b001, mk_tgt(3'd0, 3'd2, 3'd0, 2'd1), '0, '0);
    send(3'b011, opnd(3'd5, 2'd0), opnd(3'd2, 2'd0), '0, 32'h55, 32'h22, 0);
    idle(2);
    chk("R1 frame 2 operand in slot 2", out_data[31:0], 32'h22);
    chk("R4 lower slot first", 32'(out_tgt[1:0]), 32'd0);
    idle(1);
    chk("R4 higher slot next", out_data[31:0], 32'h55);
    chk("R4 higher slot target", 32'(out_tgt[1:0]), 32'd1);
    idle(2);

    // R7: three targets, three directions
    load(3'd3, 8'h01, 3'b111, mk_tgt(3'd0, 3'b111, 3'd1, 2'd0),
         mk_tgt(3'd2, 3'd0, 3'd2, 2'd1), mk_tgt(3'b111, 3'd0, 3'd3, 2'd2));
    send(3'b011, opnd(3'd3, 2'd0), opnd(3'd3, 2'd1), '0, 32'd100, 32'd23, 0);
    idle(2);
    chk("R7 all ports valid", 32'(out_valid), 32'h7);
    chk("R7 port0 column target", 32'(out_tgt[TW-1:0]), 32'(mk_tgt(3'd0, 3'b111, 3'd1, 2'd0)));
    chk("R7 port1 row-plus target", 32'(out_tgt[2*TW-1:TW]), 32'(mk_tgt(3'd2, 3'd0, 3'd2, 2'd1)));
    chk("R7 port2 row-minus target", 32'(out_tgt[3*TW-1:2*TW]), 32'(mk_tgt(3'b111, 3'd0, 3'd3, 2'd2)));
    chk("R7 port2 data", out_data[95:64], 32'd123);
    idle(2);

    // R8: two targets on one port serialise
    load(3'd4, 8'h08, 3'b011, mk_tgt(3'd1, 3'd1, 3'd6, 2'd0), mk_tgt(3'd0, 3'b110, 3'd7, 2'd1), '0);
    send(3'b001, opnd(3'd4, 2'd0), '0, '0, 32'h77, 0, 0);
    idle(2);
    chk("R8 target 0 first", 32'(out_tgt[TW-1:0]), 32'(mk_tgt(3'd1, 3'd1, 3'd6, 2'd0)));
    idle(1);
    chk("R8 target 1 second", 32'(out_tgt[TW-1:0]), 32'(mk_tgt(3'd0, 3'b110, 3'd7, 2'd1)));
    chk("R8 second valid", 32'(out_valid[0]), 32'd1);
    idle(1);
    chk("R8 port drains", 32'(out_valid[0]), 32'd0);
    idle(1);

    // R9: busy port holds, later result waits
    out_ready = 3'b110;
    load(3'd6, 8'h08, 3'b001, mk_tgt(3'd0, 3'd1, 3'd0, 2'd0), '0, '0);
    load(3'd7, 8'h08, 3'b001, mk_tgt(3'd0, 3'd1, 3'd1, 2'd0), '0, '0);
    send(3'b011, opnd(3'd6, 2'd0), opnd(3'd7, 2'd0), '0, 32'hA1, 32'hB2, 0);
    idle(2);
    chk("R9 first result", out_data[31:0], 32'hA1);
    idle(3);
    chk("R9 held while busy", out_data[31:0], 32'hA1);
    chk("R9 valid held", 32'(out_valid[0]), 32'd1);
    out_ready = 3'b111;
    idle(1);
    chk("R9 waiting result follows", out_data[31:0], 32'hB2);
    idle(1);
    chk("R9 port empties", 32'(out_valid[0]), 32'd0);
    idle(1);

    // R10: clear discards gathered operand
    load(3'd4, 8'h02, 3'b001, mk_tgt(3'd0, 3'd1, 3'd4, 2'd0), '0, '0);
    send(3'b001, opnd(3'd4, 2'd0), '0, '0, 32'd50, 0, 0);
    clr_frames = 8'h10;
    idle(1);
    clr_frames = '0;
    send(3'b010, '0, opnd(3'd4, 2'd1), '0, 0, 32'd8, 0);
    idle(2);
    chk("R10 clear drops operand", 32'(out_valid), 32'd0);
    send(3'b001, opnd(3'd4, 2'd0), '0, '0, 32'd50, 0, 0);
    idle(2);
    chk("R10 refilled slot fires", out_data[31:0], 32'd42);
    idle(2);

    // R10: reload discards gathered operand
    load(3'd1, 8'h01, 3'b001, mk_tgt(3'd0, 3'd1, 3'd1, 2'd0), '0, '0);
    send(3'b001, opnd(3'd1, 2'd0), '0, '0, 32'd1, 0, 0);
    load(3'd1, 8'h01, 3'b001, mk_tgt(3'd0, 3'd1, 3'd1, 2'd0), '0, '0);
    send(3'b010, '0, opnd(3'd1, 2'd1), '0, 0, 32'd2, 0);
    idle(2);
    chk("R10 reload drops operand", 32'(out_valid), 32'd0);
    send(3'b001, opnd(3'd1, 2'd0), '0, '0, 32'd1, 0, 0);
    idle(2);
    chk("R10 reloaded slot fires", out_data[31:0], 32'd3);
    idle(2);

    // R2: position 3 is dropped
    load(3'd0, 8'h08, 3'b001, mk_tgt(3'd0, 3'd1, 3'd0, 2'd0), '0, '0);
    send(3'b001, opnd(3'd0, 2'd3), '0, '0, 32'h99, 0, 0);
    idle(3);
    chk("R2 position 3 ignored", 32'(out_valid), 32'd0);
    send(3'b001, opnd(3'd0, 2'd0), '0, '0, 32'h98, 0, 0);
    idle(2);
    chk("R2 left position accepted", out_data[31:0], 32'h98);
    idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule